// File: doc/BRIEF.md
# Two-Level Register Write Permission Gate

This block decides whether the non-secure kernel privilege level may write each of five protected implementation-specific registers. Two of them belong to the core (an auxiliary control and an extended control register) and three to the shared cache (a control, an extended control and an auxiliary register). The decision uses two gate registers. One is owned by the hypervisor level and one by the secure-monitor level. A non-secure level-1 write reaches its target only when the matching enable bit is set in both gate registers.

Requests arrive on a system-register access port that carries the privilege level, the security state, the direction, a register select and write data. The block answers in the same cycle with read data, a single access-fault flag and a one-hot write-enable for the protected targets. The protected registers live outside this block. The block also decides whether the two gate registers may themselves be accessed, using the requester's privilege level and security state.

Top module: `perm_gate`

## Requirements
- R1: The `req_sel` encoding is as follows. Values 0 to 4 select the protected targets: core auxiliary, core extended, cache control, cache extended and cache auxiliary, in that order. Value 5 selects the hypervisor gate, 6 the monitor gate, and 7 is unmapped. Both gate registers use the same layout: bit 0 enables target 0, bit 1 target 1, bit 4 target 2, bit 5 target 3 and bit 6 target 4. `req_el` carries the level number from 0 to 3, and `req_ns`=1 means non-secure.
- R2: After reset every enable bit in both gate registers reads 0, and every non-secure level-1 write to a target faults.
- R3: Gate-register bits 31:7 and 3:2 always read 0, and writes to them are ignored.
- R4: The hypervisor gate can be read and written from level 2 and from level 3 in either security state. An access from level 0 or level 1 faults.
- R5: The monitor gate can be read and written only from level 3. An access from any other level faults.
- R6: A non-secure level-1 write to target i raises `tgt_we[i]` only when the target's enable bit is 1 in both gate registers. Otherwise the write faults.
- R7: A secure level-1 write, or any write from level 2 or level 3, to target i raises `tgt_we[i]` without checking the gate bits.
- R8: A level-0 write to any target faults and raises no write-enable.
- R9: A faulting access, including any access with select 7, drives `rd_data` to 0, raises no write-enable and leaves both gate registers unchanged. `fault` is high only in the cycle of that access.
- R10: `tgt_we` and `fault` follow the request in the same cycle. A gate-register write becomes visible from the next clock edge onward.
- R11: A read with a target select returns 0 and neither faults nor raises a write-enable. When `req_valid` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_el | input | 2 | Requester privilege level (0 to 3) |
| req_ns | input | 1 | 1 = non-secure requester |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select (see R1) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 unless a legal gate-register read |
| fault | output | 1 | Access refused |
| tgt_we | output | 5 | Per-target write-enable, one-hot or zero |

## Verification
The assertions assume a single request per cycle. They also assume that `req_el`, `req_ns`, `req_wr`, `req_sel` and `req_wdata` are stable around the clock edge, and that `req_valid` is low during reset. The bench changes its inputs only on the falling edge and holds them through the rising edge that follows. It draws every field from its full legal range, so select 7 and every combination of level and security state occur. Gate bits are set and cleared at random, which drives the non-secure level-1 checks through both the open and the closed state of each target.

// File: rtl/perm_gate_pkg.sv
package perm_gate_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_TGT = 5;
  localparam int SEL_W   = 3;
  localparam int EL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CORE_AUX = 3'd0,
    SEL_CORE_EXT = 3'd1,
    SEL_L2_CTL   = 3'd2,
    SEL_L2_EXT   = 3'd3,
    SEL_L2_AUX   = 3'd4,
    SEL_GATE_HYP = 3'd5,
    SEL_GATE_MON = 3'd6,
    SEL_NONE     = 3'd7
  } sel_e;

  // gate-register bit position that enables a target index
  function automatic int tgt_bit(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 4;
      3: return 5;
      default: return 6;
    endcase
  endfunction

  // writable bits of a gate register: exactly the enable positions
  function automatic logic [DATA_W-1:0] enable_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_TGT; k++) m[tgt_bit(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gate_reg.sv
module gate_reg
  import perm_gate_pkg::*;
#(
  parameter int              W    = DATA_W,
  parameter logic [W-1:0]    MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & MASK;
  end

  // R3: bits outside the mask never become set
  always_comb begin
    if (rst_n) a_r3_reserved_clear: assert ((q & ~MASK) == '0);
  end
endmodule

// File: rtl/access_check.sv
module access_check
  import perm_gate_pkg::*;
#(
  parameter int N = NUM_TGT
) (
  input  logic             valid,
  input  logic [EL_W-1:0]  el,
  input  logic             ns,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  logic [N-1:0]     hyp_en,
  input  logic [N-1:0]     mon_en,
  output logic             hyp_rd,
  output logic             hyp_wr,
  output logic             mon_rd,
  output logic             mon_wr,
  output logic [N-1:0]     tgt_we,
  output logic             fault
);
  logic          hyp_ok, mon_ok, is_tgt, sel_ok;
  logic [N-1:0]  tgt_ok;

  assign hyp_ok = (el >= EL_W'(2));
  assign mon_ok = (el == EL_W'(3));
  assign is_tgt = (sel < SEL_W'(N));

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_tgt
      assign tgt_ok[gi] = (el >= EL_W'(2)) ||
                          ((el == EL_W'(1)) && (!ns || (hyp_en[gi] && mon_en[gi])));
      assign tgt_we[gi] = valid && wr && (sel == SEL_W'(gi)) && tgt_ok[gi];
    end
  endgenerate

  always_comb begin
    sel_ok = 1'b0;
    for (int k = 0; k < N; k++)
      if (sel == SEL_W'(k)) sel_ok = tgt_ok[k];
  end

  always_comb begin
    fault = 1'b0;
    if (valid) begin
      case (sel_e'(sel))
        SEL_GATE_HYP: fault = !hyp_ok;
        SEL_GATE_MON: fault = !mon_ok;
        SEL_NONE:     fault = 1'b1;
        default:      fault = is_tgt && wr && !sel_ok;
      endcase
    end
  end

  assign hyp_rd = valid && !wr && (sel == SEL_GATE_HYP) && hyp_ok;
  assign hyp_wr = valid &&  wr && (sel == SEL_GATE_HYP) && hyp_ok;
  assign mon_rd = valid && !wr && (sel == SEL_GATE_MON) && mon_ok;
  assign mon_wr = valid &&  wr && (sel == SEL_GATE_MON) && mon_ok;
endmodule

// File: rtl/perm_gate.sv
module perm_gate
  import perm_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [EL_W-1:0]    req_el,
  input  logic               req_ns,
  input  logic               req_wr,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               fault,
  output logic [NUM_TGT-1:0] tgt_we
);
  localparam logic [DATA_W-1:0] MASK = enable_mask();

  logic [DATA_W-1:0]  hyp_q, mon_q;
  logic [NUM_TGT-1:0] hyp_en, mon_en;
  logic               hyp_rd, hyp_wr, mon_rd, mon_wr;

  gate_reg #(.W(DATA_W), .MASK(MASK)) u_hyp (
    .clk(clk), .rst_n(rst_n), .wr_en(hyp_wr), .wdata(req_wdata), .q(hyp_q));

  gate_reg #(.W(DATA_W), .MASK(MASK)) u_mon (
    .clk(clk), .rst_n(rst_n), .wr_en(mon_wr), .wdata(req_wdata), .q(mon_q));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TGT; gi++) begin : g_en
      assign hyp_en[gi] = hyp_q[tgt_bit(gi)];
      assign mon_en[gi] = mon_q[tgt_bit(gi)];
    end
  endgenerate

  access_check #(.N(NUM_TGT)) u_chk (
    .valid(req_valid), .el(req_el), .ns(req_ns), .wr(req_wr), .sel(req_sel),
    .hyp_en(hyp_en), .mon_en(mon_en),
    .hyp_rd(hyp_rd), .hyp_wr(hyp_wr), .mon_rd(mon_rd), .mon_wr(mon_wr),
    .tgt_we(tgt_we), .fault(fault));

  always_comb begin
    rd_data = '0;
    if (hyp_rd)      rd_data = hyp_q;
    else if (mon_rd) rd_data = mon_q;
  end

  // R6: a non-secure level-1 target write needs both gate bits
  a_r6_both_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd1 && req_ns && (tgt_we != '0))
      |-> ((tgt_we & ~(hyp_en & mon_en)) == '0));
  // R8: level 0 never gets a write-enable
  a_r8_el0_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_el == 2'd0) |-> (tgt_we == '0));
  // R9: a fault carries no data, no enable, and no gate update
  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rd_data == '0 && tgt_we == '0 && !hyp_wr && !mon_wr));
  a_r9_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(hyp_q) && $stable(mon_q)));
  // R5: the monitor gate changes only after a level-3 request
  a_r5_mon_el3_only: assert property (@(posedge clk) disable iff (!rst_n)
    mon_wr |-> (req_el == 2'd3));
  // R10: a gate write is visible one edge later
  a_r10_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_wr |=> (hyp_q == $past(req_wdata & MASK)));
  // R1: write-enables are one-hot or zero
  a_r1_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_we));
endmodule

// File: tb/sim_perm_gate.sv
module sim_perm_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_el = '0;
  logic        req_ns = 1'b0;
  logic        req_wr = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        fault;
  logic [4:0]  tgt_we;

  int tests = 0;
  int fails = 0;
  logic [31:0] m_hyp = '0;
  logic [31:0] m_mon = '0;

  always #10 clk = ~clk;

  perm_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_el(req_el),
    .req_ns(req_ns), .req_wr(req_wr), .req_sel(req_sel), .req_wdata(req_wdata),
    .rd_data(rd_data), .fault(fault), .tgt_we(tgt_we));

  function automatic int pos_of(input int t);
    int p[5] = '{0, 1, 4, 5, 6};
    return p[t];
  endfunction

  function automatic string tag_of(input logic v, input int el, input logic ns,
                                   input logic wr, input int sel);
    if (!v)       return "R11";
    if (sel == 7) return "R9";
    if (sel == 5) return wr ? "R4/R3" : "R4";
    if (sel == 6) return "R5";
    if (!wr)      return "R11";
    if (el == 0)  return "R8";
    if (el == 1 && ns) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [31:0] e_rd,
                       input logic e_f, input logic [4:0] e_we);
    tests++;
    if (rd_data !== e_rd || fault !== e_f || tgt_we !== e_we) begin
      fails++;
      $display("FAIL %s: got rd=%h f=%b we=%b, expected rd=%h f=%b we=%b",
               tag, rd_data, fault, tgt_we, e_rd, e_f, e_we);
    end
  endtask

  // one request: drive on falling edge, check before rising edge, update model
  task automatic step(input logic v, input int el, input logic ns, input logic wr,
                      input int sel, input logic [31:0] wd);
    logic [31:0] e_rd;
    logic        e_f;
    logic [4:0]  e_we;
    logic        ok;
    @(negedge clk);
    req_valid = v; req_el = el[1:0]; req_ns = ns; req_wr = wr;
    req_sel = sel[2:0]; req_wdata = wd;
    #5;
    e_rd = '0; e_f = 1'b0; e_we = '0; ok = 1'b0;
    if (v) begin
      if (sel == 5 || sel == 6) begin
        ok = (sel == 5) ? (el >= 2) : (el == 3);
        e_f = !ok;
        if (ok && !wr) e_rd = (sel == 5) ? m_hyp : m_mon;
      end else if (sel == 7) begin
        e_f = 1'b1;
      end else if (wr) begin
        if (el == 0)      ok = 1'b0;
        else if (el == 1) ok = !ns || (m_hyp[pos_of(sel)] && m_mon[pos_of(sel)]);
        else              ok = 1'b1;
        e_f = !ok;
        if (ok) e_we[sel] = 1'b1;
      end
    end
    check(tag_of(v, el, ns, wr, sel), e_rd, e_f, e_we);
    @(posedge clk);
    if (v && wr && ok && sel == 5) m_hyp = wd & 32'h0000_0073;
    if (v && wr && ok && sel == 6) m_mon = wd & 32'h0000_0073;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    // R2: reset state of both gates, and NS level-1 writes blocked
    step(1, 2, 1, 0, 5, 0);
    step(1, 3, 0, 0, 6, 0);
    for (int t = 0; t < 5; t++) step(1, 1, 1, 1, t, 32'hFFFF_FFFF);
    // R3: reserved bits dropped on write
    step(1, 2, 1, 1, 5, 32'hFFFF_FFFF);
    step(1, 3, 1, 0, 5, 0);
    // R6: only hypervisor gate open -> still blocked
    step(1, 1, 1, 1, 0, 0);
    // R5: monitor gate from level 2 faults; from level 3 succeeds
    step(1, 2, 1, 1, 6, 32'h0000_0011);
    step(1, 3, 0, 1, 6, 32'h0000_0011);
    // R10: visible next edge; R6 opened targets 0 and 2
    for (int t = 0; t < 5; t++) step(1, 1, 1, 1, t, 0);
    // R4: level-1 access to the hypervisor gate faults, state kept
    step(1, 1, 0, 1, 5, 0);
    step(1, 2, 0, 0, 5, 0);
    // R7, R8, R9, R11
    step(1, 1, 0, 1, 3, 0);
    step(1, 2, 1, 1, 4, 0);
    step(1, 0, 0, 1, 1, 0);
    step(1, 3, 0, 0, 7, 32'h1);
    step(1, 1, 1, 0, 2, 0);
    step(0, 3, 0, 1, 5, 32'hFFFF_FFFF);
    step(1, 3, 0, 0, 5, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[31:28] != 0, int'(r[1:0]), r[2], r[3], int'(r[6:4]), $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule